// File: doc/BRIEF.md
# Cipher DMA Ready/Acknowledge Flow Control

This block paces an external DMA engine that feeds input blocks to a cipher core and drains its results. It drives two ready lines: one tells the DMA that the core will take a new input block, the other tells it that a finished result is waiting. Each ready line has an acknowledge returned by the DMA. Both pairs use a four-phase handshake: ready rises, the DMA moves the data and raises its acknowledge, the block drops ready, and the DMA then lowers its acknowledge.

The block watches three events from the core side. The first is a strobe for the write of the most significant input word, which starts a cipher run. The second is the engine's busy level and its done pulse. The third is a strobe for the read of the most significant output word. It does not decode the bus and does not hold any data. A single enable turns the whole interface off. While the enable is low, both ready lines are held at zero, the acknowledges are not looked at, and any handshake in progress is dropped.

Top module: `dma_flow_ctrl`

## Requirements
- R1: While rst_n is low, tx_ready and rx_ready are 0.
- R2: While dma_en is 0, tx_ready and rx_ready are 0 in that same cycle. A handshake in progress returns to idle. tx_ack, rx_ack and engine_done seen while disabled leave no trace: no result is offered after re-enabling.
- R3: When dma_en is 1, the engine is idle, no block is loaded, no result is pending and tx_ack is low, tx_ready rises one clock edge later.
- R4: tx_ready falls at the first clock edge where tx_ack is sampled 1. It does not rise again while tx_ack stays 1. It is never raised while tx_ack is already 1.
- R5: After top_in_wr has loaded a block, tx_ready stays 0 until engine_done has been seen. While engine_busy is 1, tx_ready does not rise.
- R6: rx_ready rises at the clock edge after engine_done is sampled 1. It falls at the first edge where rx_ack is sampled 1, and the same result is not offered again.
- R7: A top_out_rd strobe while rx_ready is 1 drops rx_ready at the next edge and consumes the result.
- R8: tx_ready stays 0 while a result is pending on the receive side. It rises one edge after that result has been taken.
- R9: Once a ready line is 1, it stays 1 until its acknowledge (or top_out_rd, for rx_ready) is seen or dma_en falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Enables the flow-control interface |
| engine_busy | input | 1 | Cipher engine is processing a block |
| engine_done | input | 1 | One-cycle pulse: result is complete |
| top_in_wr | input | 1 | Write strobe of the most significant input word |
| top_out_rd | input | 1 | Read strobe of the most significant output word |
| tx_ack | input | 1 | DMA acknowledge for the input transfer |
| rx_ack | input | 1 | DMA acknowledge for the result transfer |
| tx_ready | output | 1 | Core accepts a new input block |
| rx_ready | output | 1 | A fresh result can be read |

## Verification
On every cycle, the assertions check the following rules. The interface is silent while disabled. Each ready line falls after its acknowledge or read strobe and stays low while tx_ack is held. A ready line is never withdrawn without a cause. tx_ready only rises with the engine idle and no result on offer. Only the bench's scripted sequences show the things that depend on history. These are the exact rise latency after enable and after done, a load blocking new offers until the engine finishes, a done pulse seen while disabled being forgotten, and the transmit side opening again in the cycle after a result is taken.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    // Four-phase channel phase
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_OFFER = 2'd1,
        CH_HOLD  = 2'd2
    } ch_state_e;

    typedef struct packed {
        ch_state_e st;
    } chan_regs_t;

    typedef struct packed {
        logic loaded;   // block written, engine not finished yet
        logic pending;  // result produced, not yet taken
    } track_regs_t;

endpackage

// File: rtl/dma_hs_channel.sv
module dma_hs_channel
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic offer_ok,
    input  logic ack,
    input  logic cut,
    output logic ready
);

    chan_regs_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d.st = CH_IDLE;
        end else begin
            case (q.st)
                CH_IDLE:  if (offer_ok && !ack) d.st = CH_OFFER;
                CH_OFFER: if (ack || cut)       d.st = CH_HOLD;
                CH_HOLD:  if (!ack)             d.st = CH_IDLE;
                default:                        d.st = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CH_IDLE};
        else        q <= d;
    end

    assign ready = en && (q.st == CH_OFFER);

    // R9: an offered ready is only withdrawn by ack, cut or disable
    p_keep_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !ack && !cut) |=> (ready || !en));

endmodule

// File: rtl/dma_hs_tracker.sv
module dma_hs_tracker
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic blk_wr,
    input  logic eng_done,
    input  logic res_taken,
    output logic loaded,
    output logic pending
);

    track_regs_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else begin
            if (blk_wr)        d.loaded = 1'b1;
            else if (eng_done) d.loaded = 1'b0;

            if (eng_done)       d.pending = 1'b1;
            else if (res_taken) d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign loaded  = q.loaded;
    assign pending = q.pending;

endmodule

// File: rtl/dma_flow_ctrl.sv
module dma_flow_ctrl
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic engine_busy,
    input  logic engine_done,
    input  logic top_in_wr,
    input  logic top_out_rd,
    input  logic tx_ack,
    input  logic rx_ack,
    output logic tx_ready,
    output logic rx_ready
);

    logic blk_loaded, res_pending, res_taken;
    logic tx_offer_ok, rx_offer_ok;

    assign res_taken   = rx_ready && (rx_ack || top_out_rd);
    assign rx_offer_ok = res_pending || engine_done;
    assign tx_offer_ok = !blk_loaded && !engine_busy && !res_pending
                         && !engine_done && !top_in_wr;

    dma_hs_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (dma_en),
        .blk_wr    (top_in_wr),
        .eng_done  (engine_done),
        .res_taken (res_taken),
        .loaded    (blk_loaded),
        .pending   (res_pending)
    );

    dma_hs_channel u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (dma_en),
        .offer_ok (tx_offer_ok),
        .ack      (tx_ack),
        .cut      (1'b0),
        .ready    (tx_ready)
    );

    dma_hs_channel u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (dma_en),
        .offer_ok (rx_offer_ok),
        .ack      (rx_ack),
        .cut      (top_out_rd),
        .ready    (rx_ready)
    );

    // R2: silent while disabled
    p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> (!tx_ready && !rx_ready));

    // R4: acknowledge drops tx_ready, held ack keeps it low
    p_tx_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_ack) |=> !tx_ready);
    p_tx_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && tx_ack) |=> !tx_ready);

    // R5: no offer raised while the engine was busy
    p_tx_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> !$past(engine_busy));

    // R6: result acknowledge drops rx_ready
    p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_ack) |=> !rx_ready);

    // R7: top output word read consumes the result
    p_rx_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && top_out_rd) |=> !rx_ready);

    // R8: no new input offer while a result is on offer
    p_withhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> !rx_ready);

endmodule

// File: tb/dma_flow_ctrl_tb.sv
module dma_flow_ctrl_tb;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 1'b0, engine_busy = 1'b0, engine_done = 1'b0;
    logic top_in_wr = 1'b0, top_out_rd = 1'b0, tx_ack = 1'b0, rx_ack = 1'b0;
    logic tx_ready, rx_ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  tx;
        logic  rx;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_flow_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_en      (dma_en),
        .engine_busy (engine_busy),
        .engine_done (engine_done),
        .top_in_wr   (top_in_wr),
        .top_out_rd  (top_out_rd),
        .tx_ack      (tx_ack),
        .rx_ack      (rx_ack),
        .tx_ready    (tx_ready),
        .rx_ready    (rx_ready)
    );

    task automatic compare(input logic tx, input logic rx, input string tag);
        checks++;
        if (tx_ready !== tx || rx_ready !== rx) begin
            errors++;
            $display("FAIL %s: tx_ready=%b rx_ready=%b expected tx_ready=%b rx_ready=%b",
                     tag, tx_ready, rx_ready, tx, rx);
        end
    endtask

    // Driver: apply one cycle of stimulus, queue outputs expected after the edge
    task automatic cyc(input logic en, input logic busy, input logic done,
                       input logic inwr, input logic outrd,
                       input logic txa, input logic rxa,
                       input logic etx, input logic erx, input string tag);
        exp_t e;
        @(negedge clk);
        dma_en = en; engine_busy = busy; engine_done = done;
        top_in_wr = inwr; top_out_rd = outrd; tx_ack = txa; rx_ack = rxa;
        e.tx = etx; e.rx = erx; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.tx, e.rx, e.tag);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        dma_en = 1'b1;
        @(posedge clk); #1;
        compare(1'b0, 1'b0, "R1 reset");
        @(posedge clk); #1;
        compare(1'b0, 1'b0, "R1 reset held");
        @(negedge clk);
        rst_n = 1'b1;
        //   en busy done inwr outrd txa rxa  etx erx
        cyc(0, 0, 0, 0, 0, 0, 0,  0, 0, "R2 disabled");
        cyc(0, 0, 1, 0, 0, 1, 1,  0, 0, "R2 inputs ignored");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R3 offer, R2 no stale result");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R9 offer kept");
        cyc(1, 0, 0, 1, 0, 0, 0,  1, 0, "R9 block write keeps offer");
        cyc(1, 1, 0, 0, 0, 1, 0,  0, 0, "R4 drop on tx_ack");
        cyc(1, 1, 0, 0, 0, 1, 0,  0, 0, "R4 low while ack held");
        cyc(1, 1, 0, 0, 0, 0, 0,  0, 0, "R5 busy after ack release");
        cyc(1, 1, 0, 0, 0, 0, 0,  0, 0, "R5 loaded block blocks offer");
        cyc(1, 0, 1, 0, 0, 0, 0,  0, 1, "R6 rx after done");
        cyc(1, 0, 0, 0, 0, 0, 0,  0, 1, "R8 tx withheld while pending");
        cyc(1, 0, 0, 0, 0, 0, 0,  0, 1, "R8 tx still withheld");
        cyc(1, 0, 0, 0, 0, 0, 1,  0, 0, "R6 drop on rx_ack");
        cyc(1, 0, 0, 0, 0, 0, 1,  1, 0, "R8 tx released, R6 no reoffer");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R6 rx stays low");
        cyc(1, 0, 0, 1, 0, 0, 0,  1, 0, "R9 second block write");
        cyc(1, 1, 0, 0, 0, 1, 0,  0, 0, "R4 second ack");
        cyc(1, 1, 0, 0, 0, 0, 0,  0, 0, "R5 second busy");
        cyc(1, 0, 1, 0, 0, 0, 0,  0, 1, "R6 second result");
        cyc(1, 0, 0, 0, 1, 0, 0,  0, 0, "R7 read strobe drops rx");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R7 result consumed, R8 tx back");
        cyc(0, 0, 0, 0, 0, 0, 0,  0, 0, "R2 disable mid offer");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R3 re-enable offer");
        cyc(0, 0, 0, 0, 0, 0, 0,  0, 0, "R2 disable again");
        cyc(1, 1, 0, 0, 0, 0, 0,  0, 0, "R5 busy blocks offer");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R3 offer once idle");
        cyc(0, 0, 0, 0, 0, 0, 0,  0, 0, "R2 disable third");
        cyc(1, 0, 0, 0, 0, 1, 0,  0, 0, "R4 no offer while ack high");
        cyc(1, 0, 0, 0, 0, 0, 0,  1, 0, "R3 offer after ack low");
        @(posedge clk); #2;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule